// File: doc/BRIEF.md
# Leveled Priority Interrupt Controller

The controller sits between a set of peripheral interrupt flags and a CPU core. Each source has a flag that the peripheral sets and that only software clears, an enable input, and a 3-bit priority level that software writes over a small byte-addressed register bus. In every cycle the controller picks one winner from the pending and enabled sources. The highest level wins, and on equal levels the lowest source index wins. It then drives a request line, a vector number and the winning level toward the CPU.

The request is raised only when the CPU will take it. The CPU interrupt-enable input must be 1, the winning level must be strictly above the CPU's current level threshold, and no non-maskable request may be pending. A new, stronger request replaces the presented vector and level before the CPU acknowledges the current one. The displaced request stays pending. An acknowledge pulse retires the presented source's internal pending bit. A source whose flag software clears before service is dropped without ever producing an interrupt.

Top module: `lvl_irq_ctrl`

## Requirements
- R1: Among candidate sources, the one with the numerically highest level is presented.
- R2: Among candidates sharing the highest level, the one with the lowest source index is presented.
- R3: Sources that lose arbitration stay pending and are presented once every stronger source has been acknowledged.
- R4: If a stronger source becomes pending while another is presented but not acknowledged, the vector and level outputs switch to the stronger source, and the displaced source stays pending.
- R5: A source becomes pending on a rising edge of its flag. It is dropped and never presented if its flag goes low before it is acknowledged.
- R6: An acknowledge while `irq_req` is 1 retires the presented source. That source is not presented again until its flag falls and rises again, even though the flag stays high.
- R7: `irq_req` is 1 only when all of these hold: the winning source is enabled, `cpu_ie` is 1, the winning level is strictly greater than `cpu_il`, and `nmi_pend` is 0. A disabled source is never a candidate, but its pending state is kept.
- R8: The level registers occupy bus slots 0 to 28. Slots 12 and 21 are unused, and so are slots 29 to 31. Source i sits at slot i + (i≥12) + (i≥20). The level occupies bits [2:0]. Upper read bits are 0. Unused slots read 0 and ignore writes.
- R9: The outputs are registered. A flag rise sampled at one clock edge shows on `irq_req` after the following edge, and not before. An acknowledge takes effect on the outputs at the edge that samples it.
- R10: After reset all levels are 0, nothing is pending, and `irq_req`, `irq_vec` and `irq_lvl` are 0.
- R11: `irq_vec` equals the presented source index plus the parameter `VEC_BASE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_flag | input | NUM_SRC | Sticky peripheral flags, cleared by software |
| src_en | input | NUM_SRC | Per-source interrupt enable |
| reg_we | input | 1 | Level register write strobe |
| reg_addr | input | ADDR_W | Level register byte slot |
| reg_wdata | input | 8 | Write data, level in bits [2:0] |
| reg_rdata | output | 8 | Combinational read data of the addressed slot |
| cpu_ie | input | 1 | CPU interrupt-enable bit |
| cpu_il | input | 3 | CPU current level threshold |
| nmi_pend | input | 1 | Non-maskable request pending, blocks maskable requests |
| irq_ack | input | 1 | CPU acknowledge of the presented request |
| irq_req | output | 1 | Maskable interrupt request |
| irq_vec | output | VEC_W | Presented vector number |
| irq_lvl | output | 3 | Presented level |

## Verification
The bench builds the block with 27 sources, unused slots 12 and 21, and `VEC_BASE` set to 16, so that a vector that ignores the offset cannot pass. With that build, the bench writes and reads every bus slot on both sides of each unused slot. It covers every level from 0 to 7 against every threshold, and ties between the first and last source indices. Random flag, enable, level, threshold and acknowledge traffic is compared against a bench model of the pending set, and that traffic reaches displacement and drop orderings that directed cases would miss.

// File: rtl/lvl_irq_pkg.sv
package lvl_irq_pkg;

    localparam int LVL_W = 3;
    localparam int IDX_W = 8;

    typedef logic [LVL_W-1:0] lvl_t;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] idx;
        lvl_t             lvl;
    } win_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } slot_t;

    // Map a bus slot onto a source index, skipping the two unused slots.
    function automatic slot_t decode_slot(input int slot, input int n_src,
                                          input int gap_a, input int gap_b);
        slot_t r;
        int    src;
        src   = slot - ((slot > gap_a) ? 1 : 0) - ((slot > gap_b) ? 1 : 0);
        r.hit = (slot != gap_a) && (slot != gap_b) && (src < n_src) && (slot >= 0);
        r.idx = IDX_W'(src);
        return r;
    endfunction

endpackage

// File: rtl/lvl_regfile.sv
module lvl_regfile
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC = 27,
    parameter int ADDR_W  = 5,
    parameter int HOLE_A  = 12,
    parameter int HOLE_B  = 21
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [ADDR_W-1:0]             addr,
    input  logic [7:0]                    wdata,
    output logic [7:0]                    rdata,
    output logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q
);

    slot_t sel;

    always_comb begin
        sel = decode_slot(int'(addr), NUM_SRC, HOLE_A, HOLE_B);
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_lvl
        always_ff @(posedge clk) begin
            if (rst) begin
                lvl_q[i] <= '0;
            end else if (we && sel.hit && (sel.idx == IDX_W'(i))) begin
                lvl_q[i] <= wdata[LVL_W-1:0];
            end
        end
    end

    always_comb begin
        rdata = '0;
        if (sel.hit) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (sel.idx == IDX_W'(i)) begin
                    rdata[LVL_W-1:0] = lvl_q[i];
                end
            end
        end
    end

endmodule

// File: rtl/lvl_pending.sv
module lvl_pending #(
    parameter int NUM_SRC = 27
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] flag,
    input  logic [NUM_SRC-1:0] retire,
    output logic [NUM_SRC-1:0] pend
);

    logic [NUM_SRC-1:0] flag_q;
    logic [NUM_SRC-1:0] pend_d;

    // Set on a flag rise, held while the flag stays up, retired by acknowledge.
    always_comb begin
        pend_d = flag & (pend | ~flag_q) & ~retire;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= '0;
            pend   <= '0;
        end else begin
            flag_q <= flag;
            pend   <= pend_d;
        end
    end

endmodule

// File: rtl/lvl_arbiter.sv
module lvl_arbiter
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC = 27
) (
    input  logic [NUM_SRC-1:0]            cand,
    input  logic [NUM_SRC-1:0][LVL_W-1:0] lvl,
    output win_t                          win
);

    // Ascending scan with strict compare: equal levels keep the lower index.
    always_comb begin
        win = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (cand[i] && (!win.valid || (lvl[i] > win.lvl))) begin
                win.valid = 1'b1;
                win.idx   = IDX_W'(i);
                win.lvl   = lvl[i];
            end
        end
    end

endmodule

// File: rtl/lvl_irq_ctrl.sv
module lvl_irq_ctrl
    import lvl_irq_pkg::*;
#(
    parameter int NUM_SRC  = 27,
    parameter int ADDR_W   = 5,
    parameter int HOLE_A   = 12,
    parameter int HOLE_B   = 21,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 0
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_flag,
    input  logic [NUM_SRC-1:0] src_en,
    input  logic               reg_we,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [7:0]         reg_wdata,
    output logic [7:0]         reg_rdata,
    input  logic               cpu_ie,
    input  logic [LVL_W-1:0]   cpu_il,
    input  logic               nmi_pend,
    input  logic               irq_ack,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec,
    output logic [LVL_W-1:0]   irq_lvl
);

    logic [NUM_SRC-1:0][LVL_W-1:0] lvl_q;
    logic [NUM_SRC-1:0]            pend;
    logic [NUM_SRC-1:0]            retire;
    logic [NUM_SRC-1:0]            cand;
    logic [IDX_W-1:0]              pres_idx;
    logic                          ack_hit;
    logic                          gate_ok;
    win_t                          win;

    lvl_regfile #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .HOLE_A  (HOLE_A),
        .HOLE_B  (HOLE_B)
    ) u_regs (
        .clk   (clk),
        .rst   (rst),
        .we    (reg_we),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .rdata (reg_rdata),
        .lvl_q (lvl_q)
    );

    assign ack_hit = irq_ack && irq_req;

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_retire
        assign retire[i] = ack_hit && (pres_idx == IDX_W'(i));
    end

    lvl_pending #(
        .NUM_SRC (NUM_SRC)
    ) u_pend (
        .clk    (clk),
        .rst    (rst),
        .flag   (src_flag),
        .retire (retire),
        .pend   (pend)
    );

    // The retiring source is masked at once so the next winner shows on the ack edge.
    assign cand = pend & src_flag & src_en & ~retire;

    lvl_arbiter #(
        .NUM_SRC (NUM_SRC)
    ) u_arb (
        .cand (cand),
        .lvl  (lvl_q),
        .win  (win)
    );

    assign gate_ok = win.valid && cpu_ie && !nmi_pend && (win.lvl > cpu_il);

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_req  <= 1'b0;
            irq_vec  <= '0;
            irq_lvl  <= '0;
            pres_idx <= '0;
        end else begin
            irq_req  <= gate_ok;
            pres_idx <= win.idx;
            irq_lvl  <= win.valid ? win.lvl : '0;
            irq_vec  <= win.valid ? (VEC_W'(win.idx) + VEC_W'(VEC_BASE)) : '0;
        end
    end

endmodule

// File: rtl/lvl_irq_chk.sv
module lvl_irq_chk #(
    parameter int NUM_SRC  = 27,
    parameter int ADDR_W   = 5,
    parameter int HOLE_A   = 12,
    parameter int HOLE_B   = 21,
    parameter int VEC_W    = 8,
    parameter int VEC_BASE = 0
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_flag,
    input logic               cpu_ie,
    input logic [2:0]         cpu_il,
    input logic               nmi_pend,
    input logic               irq_ack,
    input logic               irq_req,
    input logic [VEC_W-1:0]   irq_vec,
    input logic [2:0]         irq_lvl,
    input logic [ADDR_W-1:0]  reg_addr,
    input logic [7:0]         reg_rdata
);

    logic [NUM_SRC-1:0] flag_d;
    logic [NUM_SRC-1:0] flag_sh;
    logic [31:0]        pidx;
    logic               in_window;

    always_ff @(posedge clk) begin
        flag_d <= src_flag;
    end

    assign pidx      = 32'(irq_vec) - 32'(VEC_BASE);
    assign in_window = (32'(irq_vec) >= 32'(VEC_BASE)) && (pidx < 32'(NUM_SRC));
    assign flag_sh   = flag_d >> pidx;

    // R7
    gate_open_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> ($past(cpu_ie) && !$past(nmi_pend) && (irq_lvl > $past(cpu_il))));

    // R11
    vec_window_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> in_window);

    // R5
    flag_held_chk: assert property (@(posedge clk) disable iff (rst)
        irq_req |-> flag_sh[0]);

    // R6
    ack_retire_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_ack && irq_req) |=> !(irq_req && (irq_vec == $past(irq_vec))));

    // R8
    hole_read_chk: assert property (@(posedge clk) disable iff (rst)
        ((32'(reg_addr) == 32'(HOLE_A)) || (32'(reg_addr) == 32'(HOLE_B))) |-> (reg_rdata == 8'h00));

    // R8
    upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        reg_rdata[7:3] == 5'b0);

endmodule

bind lvl_irq_ctrl lvl_irq_chk #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .HOLE_A   (HOLE_A),
    .HOLE_B   (HOLE_B),
    .VEC_W    (VEC_W),
    .VEC_BASE (VEC_BASE)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .src_flag  (src_flag),
    .cpu_ie    (cpu_ie),
    .cpu_il    (cpu_il),
    .nmi_pend  (nmi_pend),
    .irq_ack   (irq_ack),
    .irq_req   (irq_req),
    .irq_vec   (irq_vec),
    .irq_lvl   (irq_lvl),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/lvl_irq_ctrl_test.sv
`timescale 1ns/1ps
module lvl_irq_ctrl_test;

    localparam int N    = 27;
    localparam int AW   = 5;
    localparam int VB   = 16;
    localparam int VW   = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  src_flag = '0;
    logic [N-1:0]  src_en = '0;
    logic          reg_we = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [7:0]    reg_wdata = '0;
    logic [7:0]    reg_rdata;
    logic          cpu_ie = 1'b0;
    logic [2:0]    cpu_il = '0;
    logic          nmi_pend = 1'b0;
    logic          irq_ack = 1'b0;
    logic          irq_req;
    logic [VW-1:0] irq_vec;
    logic [2:0]    irq_lvl;

    int checks = 0;
    int fails  = 0;

    logic [2:0]   m_lvl [N];
    logic [N-1:0] m_pend = '0;

    always #2.5 clk = ~clk;

    lvl_irq_ctrl #(
        .NUM_SRC (N), .ADDR_W (AW), .HOLE_A (12), .HOLE_B (21),
        .VEC_W (VW), .VEC_BASE (VB)
    ) uut (
        .clk (clk), .rst (rst), .src_flag (src_flag), .src_en (src_en),
        .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata), .cpu_ie (cpu_ie), .cpu_il (cpu_il),
        .nmi_pend (nmi_pend), .irq_ack (irq_ack), .irq_req (irq_req),
        .irq_vec (irq_vec), .irq_lvl (irq_lvl)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int slot_src(input int s);
        if (s == 12 || s == 21 || s > 28) return -1;
        return s - ((s > 12) ? 1 : 0) - ((s > 21) ? 1 : 0);
    endfunction

    function automatic int src_slot(input int i);
        return i + ((i >= 12) ? 1 : 0) + ((i >= 20) ? 1 : 0);
    endfunction

    // Expected winner index (or -1) from the model pending set.
    function automatic int exp_win();
        int best = -1;
        for (int i = 0; i < N; i++) begin
            if (m_pend[i] && src_en[i] && (best < 0 || m_lvl[i] > m_lvl[best])) best = i;
        end
        return best;
    endfunction

    function automatic bit exp_req();
        int w = exp_win();
        return (w >= 0) && cpu_ie && !nmi_pend && (m_lvl[w] > cpu_il);
    endfunction

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_wr(input int s, input int d);
        int k;
        reg_we = 1'b1; reg_addr = AW'(s); reg_wdata = 8'(d);
        k = slot_src(s);
        if (k >= 0) m_lvl[k] = 3'(d);
        tick();
        reg_we = 1'b0;
    endtask

    task automatic bus_rd(input int s, output int d);
        reg_addr = AW'(s);
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic set_flags(input logic [N-1:0] nf);
        for (int i = 0; i < N; i++) begin
            if (!nf[i]) m_pend[i] = 1'b0;
            else if (!src_flag[i]) m_pend[i] = 1'b1;
        end
        src_flag = nf;
    endtask

    task automatic check_out(input string tag);
        int w = exp_win();
        chk({tag, " req"}, int'(irq_req), int'(exp_req()));
        if (exp_req()) begin
            chk({tag, " vec"}, int'(irq_vec), w + VB);
            chk({tag, " lvl"}, int'(irq_lvl), int'(m_lvl[w]));
        end
    endtask

    task automatic do_ack();
        int w = exp_win();
        irq_ack = 1'b1;
        if (irq_req && w >= 0) m_pend[w] = 1'b0;
        tick();
        irq_ack = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        int d;
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) m_lvl[i] = '0;
        repeat (3) tick();
        rst = 1'b0;
        tick();

        // R10 reset state
        chk("R10 req", int'(irq_req), 0);
        chk("R10 vec", int'(irq_vec), 0);
        chk("R10 lvl", int'(irq_lvl), 0);
        for (int s = 0; s < 32; s++) begin
            bus_rd(s, d);
            chk("R10 level reg", d, 0);
        end

        // R8 bus map, holes, upper bits
        for (int s = 0; s < 32; s++) bus_wr(s, 8'hF8 | (s % 8));
        for (int s = 0; s < 32; s++) begin
            bus_rd(s, d);
            chk("R8 readback", d, (slot_src(s) >= 0) ? (s % 8) : 0);
        end
        for (int i = 0; i < N; i++) bus_wr(src_slot(i), 0);

        cpu_ie = 1'b1; cpu_il = 3'd0; src_en = '1;

        // R1 higher level wins, R11 vector offset
        bus_wr(src_slot(3), 3); bus_wr(src_slot(20), 5);
        set_flags(N'(1) << 3 | N'(1) << 20);
        tick(); tick();
        check_out("R1");
        chk("R11 vec", int'(irq_vec), 20 + VB);

        // R3 loser presented after ack of winner
        do_ack();
        check_out("R3");
        chk("R3 vec", int'(irq_vec), 3 + VB);
        do_ack();
        check_out("R6 after acks");
        chk("R6 no repeat", int'(irq_req), 0);
        set_flags('0); tick();

        // R2 tie on equal level, lowest index wins
        bus_wr(src_slot(0), 6); bus_wr(src_slot(26), 6);
        set_flags(N'(1) << 26 | N'(1));
        tick(); tick();
        check_out("R2");
        chk("R2 vec", int'(irq_vec), 0 + VB);
        set_flags('0); tick(); tick();

        // R9 latency: not after one edge, present after the second
        bus_wr(src_slot(9), 2);
        set_flags(N'(1) << 9);
        tick();
        chk("R9 one edge", int'(irq_req), 0);
        tick();
        chk("R9 two edges", int'(irq_req), 1);

        // R4 stronger request replaces before ack, displaced kept
        bus_wr(src_slot(14), 7);
        set_flags(N'(1) << 9 | N'(1) << 14);
        tick(); tick();
        check_out("R4");
        chk("R4 vec", int'(irq_vec), 14 + VB);
        do_ack();
        chk("R4 displaced vec", int'(irq_vec), 9 + VB);

        // R5 clearing the flag drops the pending source
        set_flags('0);
        tick(); tick();
        chk("R5 dropped", int'(irq_req), 0);

        // R7 gates: level vs threshold, ie, nmi, enable
        set_flags(N'(1) << 9);
        for (int t = 0; t < 8; t++) begin
            for (int l = 0; l < 8; l++) begin
                bus_wr(src_slot(9), l); cpu_il = 3'(t);
                tick(); tick();
                check_out("R7 threshold");
            end
        end
        bus_wr(src_slot(9), 4); cpu_il = 3'd1;
        cpu_ie = 1'b0; tick(); tick(); check_out("R7 ie");
        chk("R7 ie off", int'(irq_req), 0);
        cpu_ie = 1'b1; nmi_pend = 1'b1; tick(); tick();
        chk("R7 nmi", int'(irq_req), 0);
        nmi_pend = 1'b0; src_en = '0; tick(); tick();
        chk("R7 disabled", int'(irq_req), 0);
        src_en = '1; tick(); tick();
        chk("R7 pending kept", int'(irq_req), 1);
        set_flags('0); tick(); tick();

        // Random traffic against the model (R1 R2 R3 R4 R5 R6 R7)
        for (int it = 0; it < 400; it++) begin
            int op = $urandom_range(0, 9);
            if (op == 0) bus_wr(src_slot($urandom_range(0, N - 1)), $urandom_range(0, 7));
            else if (op <= 3) set_flags(src_flag | (N'(1) << $urandom_range(0, N - 1)));
            else if (op == 4) set_flags(src_flag & ~(N'(1) << $urandom_range(0, N - 1)));
            else if (op == 5) begin
                cpu_il = 3'($urandom_range(0, 3));
                cpu_ie = ($urandom_range(0, 7) != 0);
                nmi_pend = ($urandom_range(0, 9) == 0);
                src_en = src_en ^ (N'(1) << $urandom_range(0, N - 1));
            end
            tick(); tick();
            check_out("R1 random");
            if (op >= 6 && irq_req) begin
                do_ack();
                check_out("R6 random ack");
            end
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule